// File: doc/BRIEF.md
# Block-Transfer Host Register Interface

This block is the host-facing side of a block-transfer style management controller port. A byte-wide host bus reaches three registers through a small address window: a control register with handshake flags, a data port into two message buffers, and an interrupt mask register. Host writes to the data port fill an inbound message buffer. Host reads drain an outbound message buffer that the message engine has loaded.

Toward the message engine the block gives a one-cycle start strobe when the host signals that a request is ready. It also exposes the inbound byte count and an indexed read port into the inbound buffer. The engine fills the outbound buffer through an indexed write port and then issues a commit carrying the response length. An update input lets the engine raise or drop a separate attention flag, with or without an interrupt request.

The host interrupt is a level signal. It is the pending bit gated by a global interrupt-allow input. Message interpretation lives outside this block.

Top module: `bt_host_regs`

## Requirements
- R1: The address is ANDed with (WIN_SIZE−1), where WIN_SIZE defaults to 4. Masked offset 0 selects control, 1 selects data and 2 selects mask. Any other masked offset reads 0xFF, and writes to it change nothing.
- R2: Control write bits act only when written as 1. Bit0 zeroes the inbound count. Bit1 zeroes the outbound read pointer. Bit3 clears response attention. Bit4 clears side attention. Bit6 toggles host busy. A control read returns bit7 = engine busy, bit6 = host busy, bit4 = side attention, bit3 = response attention, and 0 in bits 0, 1, 2 and 5.
- R3: Writing 1 to control bit2 sets engine busy and makes `start_o` high for exactly the cycle after the write.
- R4: A data read with bytes pending returns the outbound byte at the read pointer and advances the pointer. Reading the last byte returns both the pointer and the outbound length to 0. A data read with nothing pending returns 0xFF.
- R5: A data write stores the byte at index `in_len_o` only while `in_len_o` < BUF_DEPTH. `in_len_o` grows by one on every data write and saturates at its all-ones value, so overruns stay visible.
- R6: An engine commit sets the outbound length to min(`out_commit_len`, BUF_DEPTH) and zeroes the read pointer. It also clears engine busy, sets response attention, and sets pending when the interrupt is enabled. A commit takes priority over a same-cycle control-write clear.
- R7: Mask bit0 is the enable and bit1 is pending (mask read = {6'b0, pending, enable}). Switching the enable on while response or side attention is set sets pending. Switching it off clears pending.
- R8: Writing a mask value with bit1 = 1 clears pending.
- R9: An attention update whose value differs from the current side-attention flag takes it on. When it rises with the interrupt request set, pending is set, but only if response attention is clear and the enable is on. When it falls, pending is cleared, but only if response attention is clear. An update equal to the current flag does nothing.
- R10: `cold_rst` clears both the enable and pending.
- R11: `irq_o` equals pending AND `irq_allow`.
- R12: After `rst_n` all flags, counts and pointers are 0: control and mask read 0x00, a data read returns 0xFF, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | HOST_AW | Host byte address |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe, one access per cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from the current state |
| irq_allow | input | 1 | Global interrupt gate |
| irq_o | output | 1 | Level interrupt to the host |
| cold_rst | input | 1 | Cold-reset request that clears the interrupt enable and pending bit |
| start_o | output | 1 | One-cycle request-ready strobe to the engine |
| in_len_o | output | CNT_W | Inbound byte count |
| in_rd_idx | input | IDX_W | Engine read index into the inbound buffer |
| in_rd_data | output | 8 | Inbound byte at `in_rd_idx` |
| out_we | input | 1 | Outbound buffer write enable |
| out_widx | input | IDX_W | Outbound buffer write index |
| out_wdata | input | 8 | Outbound buffer write data |
| out_commit | input | 1 | Response-ready pulse |
| out_commit_len | input | LEN_W | Response length carried with the commit |
| atn_upd | input | 1 | Side-attention update strobe |
| atn_val | input | 1 | New side-attention value |
| atn_irq | input | 1 | Interrupt request carried with a rising update |

## Verification
The assertions watch every cycle for the following. A control write with bit2 is always followed by the start strobe. The interrupt never rises without `irq_allow`. A cold reset always leaves the interrupt low on the next cycle. An empty data read returns 0xFF. Each accepted data write advances the inbound count by one. A commit always leaves response attention set and engine busy clear. Reads of offsets outside the three registers return 0xFF.

Only the bench scenarios can show the rest. These are the exact interplay of the enable, the two attention flags and the pending bit, the toggling of host busy, overrun storage, length clamping, pointer restart, and the byte-for-byte contents of both buffers under random payloads.

// File: rtl/bt_host_pkg.sv
// Package: bit positions and shared types for the block-transfer host
// register interface. The bit positions are fixed because host software
// decodes them.
package bt_host_pkg;

    // Control register bit positions
    localparam int CB_CLR_WR = 0;
    localparam int CB_CLR_RD = 1;
    localparam int CB_H2B    = 2;
    localparam int CB_B2H    = 3;
    localparam int CB_SMS    = 4;
    localparam int CB_HBUSY  = 6;
    localparam int CB_BBUSY  = 7;

    // Mask register bit positions
    localparam int MB_EN   = 0;
    localparam int MB_PEND = 1;

    // Decoded register select
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Handshake flags held by the control register
    typedef struct packed {
        logic bbusy;   // engine busy
        logic hbusy;   // host busy
        logic sms;     // side attention
        logic b2h;     // response attention
    } flag_s;

endpackage

// File: rtl/bt_addr_dec.sv
// Module: bt_addr_dec
// Masks the host address to the register window and selects one of the
// three registers. Assumes WIN_SIZE is a power of two no larger than
// 2**HOST_AW.
module bt_addr_dec
    import bt_host_pkg::*;
#(
    parameter int HOST_AW  = 8,
    parameter int WIN_SIZE = 4
) (
    input  logic [HOST_AW-1:0] host_addr,
    output reg_sel_e           sel
);
    localparam logic [HOST_AW-1:0] WIN_MASK = HOST_AW'(WIN_SIZE - 1);

    logic [HOST_AW-1:0] off;

    // Fold the address into the window and map the offset to a register.
    always_comb begin
        off = host_addr & WIN_MASK;
        if (off == HOST_AW'(0))      sel = SEL_CTRL;
        else if (off == HOST_AW'(1)) sel = SEL_DATA;
        else if (off == HOST_AW'(2)) sel = SEL_MASK;
        else                         sel = SEL_NONE;
    end
endmodule

// File: rtl/bt_msg_buf.sv
// Module: bt_msg_buf
// Byte message store with one synchronous write port and one
// combinational read port. Cleared by the synchronous reset. Assumes the
// caller keeps indices below DEPTH.
module bt_msg_buf #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem [DEPTH];

    // Write one byte per cycle; clear all entries on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Asynchronous read port.
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/bt_flag_ctl.sv
// Module: bt_flag_ctl
// Holds the handshake flags, the interrupt enable and the pending bit.
// Events in one cycle apply in this fixed order: control write, mask
// write, engine commit, attention update, cold reset. Assumes at most one
// host register write per cycle.
module bt_flag_ctl
    import bt_host_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctrl_wr,
    input  logic  h2b_go,
    input  logic  b2h_clr,
    input  logic  sms_clr,
    input  logic  hbusy_tgl,
    input  logic  mask_wr,
    input  logic  en_val,
    input  logic  pend_clr,
    input  logic  commit,
    input  logic  atn_upd,
    input  logic  atn_val,
    input  logic  atn_irq,
    input  logic  cold_rst,
    output flag_s flags,
    output logic  irq_en,
    output logic  irq_pend,
    output logic  start
);
    flag_s f_q, f_n;
    logic  en_q, en_n, pend_q, pend_n, start_q, start_n;

    // Next-state rules for the flags, the enable and the pending bit.
    always_comb begin
        f_n     = f_q;
        en_n    = en_q;
        pend_n  = pend_q;
        start_n = 1'b0;
        if (ctrl_wr) begin
            if (b2h_clr)   f_n.b2h   = 1'b0;
            if (sms_clr)   f_n.sms   = 1'b0;
            if (hbusy_tgl) f_n.hbusy = ~f_q.hbusy;
            if (h2b_go) begin
                f_n.bbusy = 1'b1;
                start_n   = 1'b1;
            end
        end
        if (mask_wr) begin
            if (en_val != en_q) begin
                if (en_val) begin
                    if (f_n.b2h || f_n.sms) pend_n = 1'b1;
                end else begin
                    pend_n = 1'b0;
                end
                en_n = en_val;
            end
            if (pend_clr) pend_n = 1'b0;
        end
        if (commit) begin
            f_n.bbusy = 1'b0;
            f_n.b2h   = 1'b1;
            if (en_n) pend_n = 1'b1;
        end
        if (atn_upd && (atn_val != f_n.sms)) begin
            f_n.sms = atn_val;
            if (atn_val) begin
                if (atn_irq && !f_n.b2h && en_n) pend_n = 1'b1;
            end else if (!f_n.b2h) begin
                pend_n = 1'b0;
            end
        end
        if (cold_rst) begin
            en_n   = 1'b0;
            pend_n = 1'b0;
        end
    end

    // State registers, zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q     <= '0;
            en_q    <= 1'b0;
            pend_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            f_q     <= f_n;
            en_q    <= en_n;
            pend_q  <= pend_n;
            start_q <= start_n;
        end
    end

    assign flags    = f_q;
    assign irq_en   = en_q;
    assign irq_pend = pend_q;
    assign start    = start_q;
endmodule

// File: rtl/bt_host_regs.sv
// Module: bt_host_regs (top)
// Host register interface of a block-transfer management port. It decodes
// control, data and mask registers, owns both message buffers and their
// counters, and drives the level interrupt. Assumes host_wr and host_rd
// are never high in the same cycle.
module bt_host_regs
    import bt_host_pkg::*;
#(
    parameter int HOST_AW   = 8,
    parameter int WIN_SIZE  = 4,
    parameter int BUF_DEPTH = 64,
    localparam int IDX_W = $clog2(BUF_DEPTH),
    localparam int LEN_W = $clog2(BUF_DEPTH + 1),
    localparam int CNT_W = $clog2(BUF_DEPTH) + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               irq_allow,
    output logic               irq_o,
    input  logic               cold_rst,
    output logic               start_o,
    output logic [CNT_W-1:0]   in_len_o,
    input  logic [IDX_W-1:0]   in_rd_idx,
    output logic [7:0]         in_rd_data,
    input  logic               out_we,
    input  logic [IDX_W-1:0]   out_widx,
    input  logic [7:0]         out_wdata,
    input  logic               out_commit,
    input  logic [LEN_W-1:0]   out_commit_len,
    input  logic               atn_upd,
    input  logic               atn_val,
    input  logic               atn_irq
);
    reg_sel_e         sel;
    flag_s            flags_w;
    logic             irq_en, irq_pend;
    logic             ctrl_wr, data_wr, mask_wr, data_rd;
    logic [CNT_W-1:0] in_len_q;
    logic [LEN_W-1:0] rd_ptr_q, out_len_q, commit_len;
    logic             rd_avail, in_store;
    logic [7:0]       out_byte;

    bt_addr_dec #(.HOST_AW(HOST_AW), .WIN_SIZE(WIN_SIZE)) u_dec (
        .host_addr (host_addr),
        .sel       (sel)
    );

    // Qualify the host strobes with the decoded register.
    always_comb begin
        ctrl_wr = host_wr && (sel == SEL_CTRL);
        data_wr = host_wr && (sel == SEL_DATA);
        mask_wr = host_wr && (sel == SEL_MASK);
        data_rd = host_rd && (sel == SEL_DATA);
    end

    bt_flag_ctl u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .h2b_go    (host_wdata[CB_H2B]),
        .b2h_clr   (host_wdata[CB_B2H]),
        .sms_clr   (host_wdata[CB_SMS]),
        .hbusy_tgl (host_wdata[CB_HBUSY]),
        .mask_wr   (mask_wr),
        .en_val    (host_wdata[MB_EN]),
        .pend_clr  (host_wdata[MB_PEND]),
        .commit    (out_commit),
        .atn_upd   (atn_upd),
        .atn_val   (atn_val),
        .atn_irq   (atn_irq),
        .cold_rst  (cold_rst),
        .flags     (flags_w),
        .irq_en    (irq_en),
        .irq_pend  (irq_pend),
        .start     (start_o)
    );

    assign in_store = data_wr && (in_len_q < CNT_W'(BUF_DEPTH));

    bt_msg_buf #(.DEPTH(BUF_DEPTH)) u_inbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_store),
        .wr_idx  (in_len_q[IDX_W-1:0]),
        .wr_data (host_wdata),
        .rd_idx  (in_rd_idx),
        .rd_data (in_rd_data)
    );

    bt_msg_buf #(.DEPTH(BUF_DEPTH)) u_outbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (out_we),
        .wr_idx  (out_widx),
        .wr_data (out_wdata),
        .rd_idx  (rd_ptr_q[IDX_W-1:0]),
        .rd_data (out_byte)
    );

    // Inbound count: cleared by control bit0, else counts every data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_len_q <= '0;
        end else if (ctrl_wr && host_wdata[CB_CLR_WR]) begin
            in_len_q <= '0;
        end else if (data_wr && (in_len_q != '1)) begin
            in_len_q <= in_len_q + CNT_W'(1);
        end
    end

    assign commit_len = (out_commit_len > LEN_W'(BUF_DEPTH)) ? LEN_W'(BUF_DEPTH)
                                                             : out_commit_len;
    assign rd_avail   = rd_ptr_q < out_len_q;

    // Outbound pointer and length: commit first, then clear, then drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q  <= '0;
            out_len_q <= '0;
        end else if (out_commit) begin
            rd_ptr_q  <= '0;
            out_len_q <= commit_len;
        end else if (ctrl_wr && host_wdata[CB_CLR_RD]) begin
            rd_ptr_q  <= '0;
        end else if (data_rd && rd_avail) begin
            if (rd_ptr_q + LEN_W'(1) == out_len_q) begin
                rd_ptr_q  <= '0;
                out_len_q <= '0;
            end else begin
                rd_ptr_q  <= rd_ptr_q + LEN_W'(1);
            end
        end
    end

    // Host read data multiplexer.
    always_comb begin
        unique case (sel)
            SEL_CTRL: host_rdata = {flags_w.bbusy, flags_w.hbusy, 1'b0,
                                    flags_w.sms, flags_w.b2h, 3'b000};
            SEL_DATA: host_rdata = rd_avail ? out_byte : 8'hFF;
            SEL_MASK: host_rdata = {6'b0, irq_pend, irq_en};
            default:  host_rdata = 8'hFF;
        endcase
    end

    assign in_len_o = in_len_q;
    assign irq_o    = irq_pend && irq_allow;
endmodule

// File: rtl/bt_host_regs_chk.sv
// Module: bt_host_regs_chk
// Checker bound to bt_host_regs. It watches the port behaviour plus the
// outbound length and the two engine-facing flags.
module bt_host_regs_chk #(
    parameter int HOST_AW  = 8,
    parameter int WIN_SIZE = 4,
    parameter int CNT_W    = 8,
    parameter int LEN_W    = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HOST_AW-1:0] host_addr,
    input logic               host_wr,
    input logic               host_rd,
    input logic [7:0]         host_wdata,
    input logic [7:0]         host_rdata,
    input logic               irq_allow,
    input logic               irq_o,
    input logic               cold_rst,
    input logic               start_o,
    input logic [CNT_W-1:0]   in_len_o,
    input logic               out_commit,
    input logic               b2h,
    input logic               bbusy,
    input logic [LEN_W-1:0]   out_len
);
    localparam logic [HOST_AW-1:0] WMASK = HOST_AW'(WIN_SIZE - 1);

    logic [HOST_AW-1:0] off;
    assign off = host_addr & WMASK;

    AST_START_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && off == HOST_AW'(0) && host_wdata[2]) |=> start_o) // R3
        else $error("start strobe missing");

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_allow) // R11
        else $error("irq without allow");

    AST_COLD_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        cold_rst |=> !irq_o) // R10
        else $error("irq after cold reset");

    AST_EMPTY_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && off == HOST_AW'(1) && out_len == '0) |-> host_rdata == 8'hFF) // R4
        else $error("empty read not FF");

    AST_IN_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && off == HOST_AW'(1) && in_len_o != '1)
            |=> in_len_o == $past(in_len_o) + CNT_W'(1)) // R5
        else $error("inbound count step");

    AST_COMMIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        out_commit |=> (b2h && !bbusy)) // R6
        else $error("commit flags");

    AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && off > HOST_AW'(2)) |-> host_rdata == 8'hFF) // R1
        else $error("unmapped read not FF");

    logic unused_ok;
    assign unused_ok = ^host_wdata[7:3] ^ ^host_wdata[1:0];
endmodule

bind bt_host_regs bt_host_regs_chk #(
    .HOST_AW (HOST_AW),
    .WIN_SIZE(WIN_SIZE),
    .CNT_W   (CNT_W),
    .LEN_W   (LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq_allow  (irq_allow),
    .irq_o      (irq_o),
    .cold_rst   (cold_rst),
    .start_o    (start_o),
    .in_len_o   (in_len_o),
    .out_commit (out_commit),
    .b2h        (flags_w.b2h),
    .bbusy      (flags_w.bbusy),
    .out_len    (out_len_q)
);

// File: tb/bt_host_regs_tb.sv
// Bench for bt_host_regs: directed corner cases plus seeded random payloads.
module bt_host_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int IDX_W = 6;
    localparam int LEN_W = 7;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       host_addr = '0;
    logic             host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]       host_wdata = '0;
    logic [7:0]       host_rdata;
    logic             irq_allow = 1'b0, irq_o, cold_rst = 1'b0, start_o;
    logic [CNT_W-1:0] in_len_o;
    logic [IDX_W-1:0] in_rd_idx = '0;
    logic [7:0]       in_rd_data;
    logic             out_we = 1'b0;
    logic [IDX_W-1:0] out_widx = '0;
    logic [7:0]       out_wdata = '0;
    logic             out_commit = 1'b0;
    logic [LEN_W-1:0] out_commit_len = '0;
    logic             atn_upd = 1'b0, atn_val = 1'b0, atn_irq = 1'b0;

    int total = 0;
    int bad = 0;
    logic [7:0] pay [DEPTH];
    logic [7:0] sent [70];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bt_host_regs u_dut (.*);

    function automatic logic [7:0] exp_ctrl(input logic bb, hb, sm, rs);
        return {bb, hb, 1'b0, sm, rs, 3'b000};
    endfunction

    function automatic logic [7:0] exp_mask(input logic en, pd);
        return {6'b0, pd, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic load_commit(input int n, input int len);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            out_we = 1'b1; out_widx = IDX_W'(i); out_wdata = pay[i];
            @(posedge clk); #1;
            out_we = 1'b0;
        end
        @(negedge clk);
        out_commit = 1'b1; out_commit_len = LEN_W'(len);
        @(posedge clk); #1;
        out_commit = 1'b0;
    endtask

    task automatic atn(input logic v, input logic irq);
        @(negedge clk);
        atn_upd = 1'b1; atn_val = v; atn_irq = irq;
        @(posedge clk); #1;
        atn_upd = 1'b0;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        int errs;
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R12 reset state
        hrd(8'd0, d); chk("R12 ctrl", d, 8'h00);
        hrd(8'd2, d); chk("R12 mask", d, 8'h00);
        hrd(8'd1, d); chk("R12 data", d, 8'hFF);
        chk("R12 irq", irq_o, 0);
        chk("R12 inlen", in_len_o, 0);

        // R5 / R1 inbound writes, aliasing and unmapped offset
        for (int i = 0; i < 3; i++) begin
            sent[i] = 8'($urandom);
            hwr((i == 2) ? 8'd5 : 8'd1, sent[i]);
        end
        chk("R5 count", in_len_o, 3);
        for (int i = 0; i < 3; i++) begin
            in_rd_idx = IDX_W'(i); #1;
            chk("R5 R1 content", in_rd_data, sent[i]);
        end
        hwr(8'd3, 8'hFF);
        chk("R1 unmapped write ignored", in_len_o, 3);
        hrd(8'd0, d); chk("R1 unmapped write no flags", d, 8'h00);
        hrd(8'd7, d); chk("R1 unmapped read", d, 8'hFF);

        // R2 clear-write
        hwr(8'd0, 8'h01);
        chk("R2 clear write", in_len_o, 0);

        // R5 overrun
        for (int i = 0; i < 66; i++) begin
            sent[i] = 8'($urandom);
            hwr(8'd1, sent[i]);
        end
        chk("R5 overrun count", in_len_o, 66);
        in_rd_idx = 6'd63; #1;
        chk("R5 last stored", in_rd_data, sent[63]);
        in_rd_idx = 6'd0; #1;
        chk("R5 first kept", in_rd_data, sent[0]);
        hwr(8'd0, 8'h01);

        // R3 start strobe and engine busy
        hwr(8'd0, 8'h04);
        chk("R3 start high", start_o, 1);
        @(posedge clk); #1;
        chk("R3 start one cycle", start_o, 0);
        hrd(8'd0, d); chk("R3 busy", d, exp_ctrl(1, 0, 0, 0));

        // R7 enable with no attention
        irq_allow = 1'b1;
        hwr(8'd2, 8'h01);
        hrd(8'd2, d); chk("R7 enable only", d, exp_mask(1, 0));

        // R6 R11 commit raises interrupt
        for (int i = 0; i < DEPTH; i++) pay[i] = 8'($urandom);
        load_commit(5, 5);
        chk("R6 R11 irq", irq_o, 1);
        hrd(8'd0, d); chk("R6 ctrl", d, exp_ctrl(0, 0, 0, 1));
        irq_allow = 1'b0; #1;
        chk("R11 gated", irq_o, 0);
        irq_allow = 1'b1;

        // R4 drain
        errs = 0;
        for (int i = 0; i < 5; i++) begin
            hrd(8'd1, d);
            if (d !== pay[i]) errs++;
        end
        chk("R4 drain", errs, 0);
        hrd(8'd1, d); chk("R4 empty", d, 8'hFF);

        // R2 clear-read restarts the pointer
        load_commit(4, 4);
        hrd(8'd1, d); hrd(8'd1, d);
        hwr(8'd0, 8'h02);
        errs = 0;
        for (int i = 0; i < 4; i++) begin
            hrd(8'd1, d);
            if (d !== pay[i]) errs++;
        end
        chk("R2 clear read", errs, 0);

        // R8 pending clear
        hwr(8'd2, 8'h03);
        hrd(8'd2, d); chk("R8 mask", d, exp_mask(1, 0));
        chk("R8 irq", irq_o, 0);

        // R2 attention clear and host busy toggle
        hwr(8'd0, 8'h08);
        hrd(8'd0, d); chk("R2 b2h clear", d, exp_ctrl(0, 0, 0, 0));
        hwr(8'd0, 8'h40);
        hrd(8'd0, d); chk("R2 hbusy set", d, exp_ctrl(0, 1, 0, 0));
        hwr(8'd0, 8'h40);
        hrd(8'd0, d); chk("R2 hbusy clear", d, exp_ctrl(0, 0, 0, 0));

        // R9 / R7 attention and enable interplay
        hwr(8'd2, 8'h00);
        atn(1'b1, 1'b1);
        hrd(8'd0, d); chk("R9 sms set", d, exp_ctrl(0, 0, 1, 0));
        hrd(8'd2, d); chk("R9 disabled no pend", d, exp_mask(0, 0));
        hwr(8'd2, 8'h01);
        hrd(8'd2, d); chk("R7 enable with sms", d, exp_mask(1, 1));
        atn(1'b0, 1'b0);
        hrd(8'd2, d); chk("R9 fall clears", d, exp_mask(1, 0));
        atn(1'b1, 1'b1);
        hrd(8'd2, d); chk("R9 rise sets", d, exp_mask(1, 1));
        hwr(8'd2, 8'h00);
        hrd(8'd2, d); chk("R7 disable clears", d, exp_mask(0, 0));
        hwr(8'd2, 8'h01);
        load_commit(1, 1);
        atn(1'b0, 1'b0);
        hrd(8'd2, d); chk("R9 fall with b2h keeps", d, exp_mask(1, 1));
        hwr(8'd0, 8'h10);
        hrd(8'd0, d); chk("R2 sms clear", d, exp_ctrl(0, 0, 0, 1));

        // R10 cold reset
        @(negedge clk) cold_rst = 1'b1;
        @(posedge clk); #1 cold_rst = 1'b0;
        hrd(8'd2, d); chk("R10 mask", d, exp_mask(0, 0));
        chk("R10 irq", irq_o, 0);
        hrd(8'd1, d); chk("R4 one byte", d, pay[0]);

        // R6 length clamp
        load_commit(DEPTH, 100);
        errs = 0;
        for (int i = 0; i < DEPTH; i++) begin
            hrd(8'd1, d);
            if (d !== pay[i]) errs++;
        end
        chk("R6 clamp data", errs, 0);
        hrd(8'd1, d); chk("R6 clamp end", d, 8'hFF);

        // R4 R5 random payloads
        for (int it = 0; it < 20; it++) begin
            int n;
            n = 1 + int'($urandom % DEPTH);
            for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
            load_commit(n, n);
            errs = 0;
            for (int i = 0; i < n; i++) begin
                hrd(8'd1, d);
                if (d !== pay[i]) errs++;
            end
            hrd(8'd1, d);
            if (d !== 8'hFF) errs++;
            chk("R4 random readback", errs, 0);
            hwr(8'd0, 8'h01);
            n = 1 + int'($urandom % 8);
            for (int i = 0; i < n; i++) begin
                sent[i] = 8'($urandom);
                hwr(8'd1, sent[i]);
            end
            errs = 0;
            for (int i = 0; i < n; i++) begin
                in_rd_idx = IDX_W'(i); #1;
                if (in_rd_data !== sent[i]) errs++;
            end
            if (in_len_o !== CNT_W'(n)) errs++;
            chk("R5 random inbound", errs, 0);
        end

        summary();
        $finish;
    end
endmodule